// File: doc/BRIEF.md
# Sectioned Pin Controller

This block drives and samples 32 general-purpose pins through a small synchronous register bus. The pins are grouped into four identical sections of eight. Each section has its own 64-byte window in which software sets the pin direction, sets the output value, reads the sampled inputs and controls the per-pin interrupts. Pin N belongs to section N/8 and occupies bit N mod 8 in every register of that section. Registers hold eight meaningful bits. The upper bits of a read are zero and the upper bits of a write are ignored.

Pad inputs pass through a two-stage synchronizer before anything else uses them. A pin's interrupt can be edge-style or level-style. An edge pin latches its status on a rising input edge until software clears it. A level pin's status tracks the input. Mask bits are changed through separate write-only set and clear offsets. A single `irq` output is the OR of every unmasked status bit in all four sections. Reads are combinational from `bus_addr`. Writes take effect on the clock edge at which `bus_we` is high.

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset every pin is an input (direction 0xFF), the output register is 0, every mask bit is 1, every pin is edge-style, every status bit is 0, `pad_oe` is 0 and `irq` is 0.
- R2: Section s decodes bus addresses s*0x40 to s*0x40+0x3F (address bits 7:6 select the section). Pin N maps to section N>>3, bit N&7, so bit 2 of section 1 is pad 10.
- R3: Direction register, offset 0x10: bit 1 = input, bit 0 = output. `pad_oe` bit is the inverse of the direction bit. `pad_out` carries the output register at offset 0x14, which reads back what was written.
- R4: Offset 0x18 returns the pad input after two clock stages. A pad change made after edge E0 is still invisible after edge E1 and reads back after edge E2.
- R5: An edge-style pin sets its status bit at offset 0x04 one edge after its synchronized input rises (after edge E3 for a pad change after E0). The bit stays set after the input falls.
- R6: Writing offset 0x04 clears every status bit written as 1. Bits written as 0 are unchanged.
- R7: Writing 1s to offset 0x0C sets mask bits. Writing 1s to offset 0x08 clears them. Zero bits change nothing. Reading 0x08 returns the mask.
- R8: Offset 0x00 reads the status ANDed with the inverted mask.
- R9: `irq` is 1 exactly when some section has a status bit that is 1 and whose mask bit is 0.
- R10: Offset 0x20 reads the level-select bits. Writing 1s sets them, and 0 bits leave them unchanged. A level pin's status equals its synchronized input delayed by one edge, so a clear write has no lasting effect while the input stays high.
- R11: Reads of undefined offsets (0x1C, 0x24-0x3C, non-multiple-of-4 offsets) return 0, and writes to them change nothing. Writes to offsets 0x00 and 0x18 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address: section in bits 7:6, offset in bits 5:0 |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data; bits 7:0 used |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pad_in | input | 32 | Asynchronous pad input levels |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables, 1 = driving |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters: four sections of eight pins in 64-byte windows. With these values, both section-select address bits are exercised, and so are the pad slices at both ends of the 32-bit vector. The exact synchronizer latency can be counted edge by edge against the read port. The reads step one cycle at a time to catch the input going invisible and then visible. They also show the edge-status latch lagging one further edge, and a clear write on a level pin being overwritten within a cycle.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  // Byte offsets inside one section window
  localparam int PB_OFF_MSTAT  = 'h00;
  localparam int PB_OFF_STAT   = 'h04;
  localparam int PB_OFF_UNMASK = 'h08;
  localparam int PB_OFF_MASK   = 'h0C;
  localparam int PB_OFF_DIR    = 'h10;
  localparam int PB_OFF_OUT    = 'h14;
  localparam int PB_OFF_IN     = 'h18;
  localparam int PB_OFF_LVL    = 'h20;

  // Default geometry
  localparam int PB_SECT_PINS  = 8;
  localparam int PB_NUM_SECT   = 4;
  localparam int PB_SECT_AW    = 6;
endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_async;
      stage2_q <= stage1_q;
    end
  end

  assign q_sync = stage2_q;
endmodule

// File: rtl/pinbank_section.sv
module pinbank_section
  import pinbank_pkg::*;
#(
  parameter int PINS   = PB_SECT_PINS,
  parameter int OFF_W  = PB_SECT_AW,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  off,
  input  logic [PINS-1:0]   wdata,
  input  logic [PINS-1:0]   sync_in,
  output logic [DATA_W-1:0] rdata,
  output logic [PINS-1:0]   out_q,
  output logic [PINS-1:0]   dir_q,
  output logic [PINS-1:0]   status_q,
  output logic [PINS-1:0]   mask_q,
  output logic [PINS-1:0]   level_q,
  output logic [PINS-1:0]   rise,
  output logic [PINS-1:0]   clr_bits,
  output logic              wr_dir_o,
  output logic              wr_mskset_o
);
  // Status next-state: level pins follow input, edge pins latch rises
  function automatic logic [PINS-1:0] status_next(
    input logic [PINS-1:0] cur,
    input logic [PINS-1:0] lvl,
    input logic [PINS-1:0] lvl_in,
    input logic [PINS-1:0] up,
    input logic [PINS-1:0] clr
  );
    return (lvl & lvl_in) | (~lvl & ((cur & ~clr) | up));
  endfunction

  function automatic logic hit(input logic [OFF_W-1:0] o, input int target);
    return o == OFF_W'(target);
  endfunction

  logic [PINS-1:0] prev_q;
  logic            wr_stat, wr_unmask, wr_mask, wr_dir, wr_out, wr_lvl;

  assign wr_stat   = wr_en && hit(off, PB_OFF_STAT);
  assign wr_unmask = wr_en && hit(off, PB_OFF_UNMASK);
  assign wr_mask   = wr_en && hit(off, PB_OFF_MASK);
  assign wr_dir    = wr_en && hit(off, PB_OFF_DIR);
  assign wr_out    = wr_en && hit(off, PB_OFF_OUT);
  assign wr_lvl    = wr_en && hit(off, PB_OFF_LVL);

  assign rise        = sync_in & ~prev_q;
  assign clr_bits    = wr_stat ? wdata : '0;
  assign wr_dir_o    = wr_dir;
  assign wr_mskset_o = wr_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q    <= '1;
      out_q    <= '0;
      mask_q   <= '1;
      level_q  <= '0;
      status_q <= '0;
      prev_q   <= '0;
    end else begin
      prev_q   <= sync_in;
      status_q <= status_next(status_q, level_q, sync_in, rise, clr_bits);
      if (wr_dir)    dir_q   <= wdata;
      if (wr_out)    out_q   <= wdata;
      if (wr_mask)   mask_q  <= mask_q | wdata;
      if (wr_unmask) mask_q  <= mask_q & ~wdata;
      if (wr_lvl)    level_q <= level_q | wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if      (hit(off, PB_OFF_MSTAT))  rdata[PINS-1:0] = status_q & ~mask_q;
    else if (hit(off, PB_OFF_STAT))   rdata[PINS-1:0] = status_q;
    else if (hit(off, PB_OFF_UNMASK)) rdata[PINS-1:0] = mask_q;
    else if (hit(off, PB_OFF_DIR))    rdata[PINS-1:0] = dir_q;
    else if (hit(off, PB_OFF_OUT))    rdata[PINS-1:0] = out_q;
    else if (hit(off, PB_OFF_IN))     rdata[PINS-1:0] = sync_in;
    else if (hit(off, PB_OFF_LVL))    rdata[PINS-1:0] = level_q;
  end
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
  import pinbank_pkg::*;
#(
  parameter int NUM_SECT  = PB_NUM_SECT,
  parameter int SECT_PINS = PB_SECT_PINS,
  parameter int SECT_AW   = PB_SECT_AW,
  parameter int DATA_W    = 32
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [$clog2(NUM_SECT)+SECT_AW-1:0]   bus_addr,
  input  logic                                  bus_we,
  input  logic [DATA_W-1:0]                     bus_wdata,
  output logic [DATA_W-1:0]                     bus_rdata,
  input  logic [NUM_SECT*SECT_PINS-1:0]         pad_in,
  output logic [NUM_SECT*SECT_PINS-1:0]         pad_out,
  output logic [NUM_SECT*SECT_PINS-1:0]         pad_oe,
  output logic                                  irq
);
  localparam int SEL_W  = $clog2(NUM_SECT);
  localparam int ADDR_W = SEL_W + SECT_AW;
  localparam int PINS   = NUM_SECT * SECT_PINS;

  logic [SEL_W-1:0]   sect_sel;
  logic [SECT_AW-1:0] sect_off;
  logic [PINS-1:0]    sync_all;
  logic [PINS-1:0]    status_all, mask_all, level_all, dir_all, out_all;
  logic [PINS-1:0]    rise_all, clr_all;
  logic [NUM_SECT-1:0] wr_dir, wr_mskset;
  logic [DATA_W-1:0]  sec_rd [NUM_SECT];

  assign sect_sel = bus_addr[ADDR_W-1:SECT_AW];
  assign sect_off = bus_addr[SECT_AW-1:0];

  pinbank_sync #(.W(PINS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pad_in),
    .q_sync  (sync_all)
  );

  for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
    pinbank_section #(
      .PINS   (SECT_PINS),
      .OFF_W  (SECT_AW),
      .DATA_W (DATA_W)
    ) u_section (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (bus_we && (sect_sel == SEL_W'(s))),
      .off         (sect_off),
      .wdata       (bus_wdata[SECT_PINS-1:0]),
      .sync_in     (sync_all[s*SECT_PINS +: SECT_PINS]),
      .rdata       (sec_rd[s]),
      .out_q       (out_all[s*SECT_PINS +: SECT_PINS]),
      .dir_q       (dir_all[s*SECT_PINS +: SECT_PINS]),
      .status_q    (status_all[s*SECT_PINS +: SECT_PINS]),
      .mask_q      (mask_all[s*SECT_PINS +: SECT_PINS]),
      .level_q     (level_all[s*SECT_PINS +: SECT_PINS]),
      .rise        (rise_all[s*SECT_PINS +: SECT_PINS]),
      .clr_bits    (clr_all[s*SECT_PINS +: SECT_PINS]),
      .wr_dir_o    (wr_dir[s]),
      .wr_mskset_o (wr_mskset[s])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int s = 0; s < NUM_SECT; s++) begin
      if (sect_sel == SEL_W'(s)) bus_rdata = sec_rd[s];
    end
  end

  assign pad_out = out_all;
  assign pad_oe  = ~dir_all;
  assign irq     = |(status_all & ~mask_all);
endmodule

// File: rtl/pinbank_ctrl_chk.sv
module pinbank_ctrl_chk #(
  parameter int PINS      = 32,
  parameter int NUM_SECT  = 4,
  parameter int SECT_PINS = 8,
  parameter int DATA_W    = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic                irq,
  input logic [PINS-1:0]     pad_oe,
  input logic [PINS-1:0]     status_all,
  input logic [PINS-1:0]     mask_all,
  input logic [PINS-1:0]     level_all,
  input logic [PINS-1:0]     sync_all,
  input logic [PINS-1:0]     rise_all,
  input logic [PINS-1:0]     clr_all,
  input logic [NUM_SECT-1:0] wr_dir,
  input logic [NUM_SECT-1:0] wr_mskset
);
  for (genvar i = 0; i < PINS; i++) begin : g_pin
    AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_all[i] && !level_all[i] |=> status_all[i]); // R5
    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      status_all[i] && !level_all[i] && !clr_all[i] |=> status_all[i]); // R5
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all[i] && !level_all[i] && !rise_all[i] |=> !status_all[i]); // R6
    AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      level_all[i] |=> status_all[i] == $past(sync_all[i])); // R10
    AST_LEVEL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      level_all[i] |=> level_all[i]); // R10
  end

  for (genvar s = 0; s < NUM_SECT; s++) begin : g_sec
    AST_DIR_DRIVES_OE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dir[s] |=> pad_oe[s*SECT_PINS +: SECT_PINS] == ~$past(bus_wdata[SECT_PINS-1:0])); // R3
    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mskset[s] |=> (mask_all[s*SECT_PINS +: SECT_PINS] & $past(bus_wdata[SECT_PINS-1:0]))
                       == $past(bus_wdata[SECT_PINS-1:0])); // R7
  end

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_all) |-> !irq); // R9
endmodule

bind pinbank_ctrl pinbank_ctrl_chk #(
  .PINS      (PINS),
  .NUM_SECT  (NUM_SECT),
  .SECT_PINS (SECT_PINS),
  .DATA_W    (DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wdata  (bus_wdata),
  .irq        (irq),
  .pad_oe     (pad_oe),
  .status_all (status_all),
  .mask_all   (mask_all),
  .level_all  (level_all),
  .sync_all   (sync_all),
  .rise_all   (rise_all),
  .clr_all    (clr_all),
  .wr_dir     (wr_dir),
  .wr_mskset  (wr_mskset)
);

// File: tb/pinbank_ctrl_bench.sv
`timescale 1ns/1ps
module pinbank_ctrl_bench;
  localparam logic [1:0] K_RD = 2'd0, K_IRQ = 2'd1, K_OE = 2'd2, K_OUT = 2'd3;

  typedef struct packed {
    logic [1:0]  kind;
    logic [31:0] exp;
    logic [7:0]  req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;
  logic        irq;

  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;
  item_t q[$];
  item_t it;
  logic [31:0] act;

  always #4 clk = ~clk;

  pinbank_ctrl u_pinbank_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .irq       (irq)
  );

  // Monitor: compare the item queued for this cycle at the falling edge
  always @(negedge clk) begin
    if (q.size() != 0) begin
      it = q.pop_front();
      case (it.kind)
        K_RD:    act = bus_rdata;
        K_IRQ:   act = {31'd0, irq};
        K_OE:    act = pad_oe;
        default: act = pad_out;
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL R%0d kind %0d addr %h actual %h expected %h",
                 it.req, it.kind, bus_addr, act, it.exp);
      end
    end
  end

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      bus_we = 1'b0;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic chk_rd(input logic [7:0] a, input logic [31:0] e, input int r);
    @(posedge clk); #1;
    bus_we = 1'b0; bus_addr = a;
    q.push_back('{kind: K_RD, exp: e, req: 8'(r)});
  endtask

  task automatic chk_sig(input logic [1:0] k, input logic [31:0] e, input int r);
    @(posedge clk); #1;
    bus_we = 1'b0;
    q.push_back('{kind: k, exp: e, req: 8'(r)});
  endtask

  task automatic setpad(input logic [31:0] v);
    @(posedge clk); #1;
    bus_we = 1'b0; pad_in = v;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R0 actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; pad_in = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state in every section
    for (int s = 0; s < 4; s++) begin
      chk_rd(8'(s * 64 + 'h10), 32'hFF, 1);
      chk_rd(8'(s * 64 + 'h14), 32'h00, 1);
      chk_rd(8'(s * 64 + 'h08), 32'hFF, 1);
      chk_rd(8'(s * 64 + 'h20), 32'h00, 1);
      chk_rd(8'(s * 64 + 'h04), 32'h00, 1);
    end
    chk_sig(K_OE, 32'h0, 1);   // R1
    chk_sig(K_IRQ, 32'h0, 1);  // R1

    // R3: direction and output in section 1
    wr(8'h50, 32'hF0);
    chk_sig(K_OE, 32'h0000_0F00, 3);
    wr(8'h54, 32'hA5);
    chk_sig(K_OUT, 32'h0000_A500, 3);
    chk_rd(8'h54, 32'hA5, 3);
    // R2: pin 10 is section 1 bit 2; section 3 sits at 0xC0
    wr(8'h54, 32'h04);
    chk_sig(K_OUT, 32'h0000_0400, 2);
    wr(8'hD0, 32'h00);
    chk_sig(K_OE, 32'hFF00_0F00, 2);

    // R4: pins 17 and 20 (section 2), two-stage latency
    setpad(32'h0012_0000);
    chk_rd(8'h98, 32'h00, 4);
    chk_rd(8'h98, 32'h12, 4);
    chk_rd(8'h84, 32'h12, 5);  // R5 captured one edge later
    setpad(32'h0);
    idle(3);
    chk_rd(8'h84, 32'h12, 5);  // R5 held after fall
    chk_rd(8'h80, 32'h00, 8);  // R8 all masked
    chk_sig(K_IRQ, 32'h0, 9);  // R9

    // R7: mask clear / set
    wr(8'h88, 32'h02);
    chk_rd(8'h88, 32'hFD, 7);
    chk_rd(8'h80, 32'h02, 8);  // R8
    chk_sig(K_IRQ, 32'h1, 9);  // R9
    wr(8'h8C, 32'h02);
    chk_rd(8'h88, 32'hFF, 7);
    chk_sig(K_IRQ, 32'h0, 9);  // R9
    wr(8'h88, 32'h12);
    chk_rd(8'h88, 32'hED, 7);

    // R6: write-one-to-clear
    wr(8'h84, 32'h02);
    chk_rd(8'h84, 32'h10, 6);
    chk_rd(8'h80, 32'h10, 8);  // R8
    chk_sig(K_IRQ, 32'h1, 9);  // R9
    wr(8'h84, 32'h10);
    chk_rd(8'h84, 32'h00, 6);
    chk_sig(K_IRQ, 32'h0, 6);

    // R10: level-style pin 24 in section 3
    wr(8'hE0, 32'h01);
    chk_rd(8'hE0, 32'h01, 10);
    wr(8'hE0, 32'h80);
    chk_rd(8'hE0, 32'h81, 10);
    setpad(32'h0100_0000);
    idle(2);
    chk_rd(8'hC4, 32'h01, 10);
    wr(8'hC4, 32'h01);
    chk_rd(8'hC4, 32'h01, 10);  // clear overridden by high level
    wr(8'hC8, 32'h01);
    chk_sig(K_IRQ, 32'h1, 10);
    setpad(32'h0);
    idle(2);
    chk_rd(8'hC4, 32'h00, 10);
    chk_sig(K_IRQ, 32'h0, 10);

    // R9: section 0 pin 0
    setpad(32'h0000_0001);
    idle(2);
    wr(8'h08, 32'h01);
    chk_sig(K_IRQ, 32'h1, 9);
    chk_rd(8'h00, 32'h01, 8);  // R8

    // R11: read-only and undefined offsets
    wr(8'h18, 32'hFF);
    chk_rd(8'h18, 32'h01, 11);
    wr(8'h00, 32'hFF);
    chk_rd(8'h00, 32'h01, 11);
    wr(8'h1C, 32'hFF);
    chk_rd(8'h1C, 32'h00, 11);
    wr(8'h24, 32'h00);
    chk_rd(8'h10, 32'hFF, 11);
    wr(8'h11, 32'h00);
    chk_rd(8'h10, 32'hFF, 11);
    chk_rd(8'h11, 32'h00, 11);
    chk_rd(8'h3C, 32'h00, 11);
    chk_rd(8'h08, 32'hFE, 11);

    idle(3);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule